// File: doc/BRIEF.md
# Windowed Output Discrepancy Evaluator

This block scores how closely two replica lanes of a triplicated datapath agree. For every valid sample it takes the absolute difference between the two lane values, squares it, and adds it to an accumulator. Once a fixed number of counted samples has passed, it reports the total as a fitness score with a one-cycle valid pulse. It then starts the next window from zero. A score of zero means the two lanes agreed on every counted sample, and a lower score always means a better fit. The score is built only from the live sample stream. No stored stimulus or golden result is involved.

The square root of a true Euclidean distance is left out. Taking the root does not change how scores rank against each other, so the sum of squares serves the same purpose. The accumulator saturates at its largest value instead of wrapping, so a badly disagreeing pair can never look healthy.

When the datapath is rearranged, the controller pulses `cfg_change`. This throws away the partial window. The block then ignores a fixed number of valid samples, which lets results still in flight from the old arrangement drain out of the pipeline. Separately, a registered per-sample disagreement flag is produced for counted samples, and it serves as the trigger for recovery.

Top module: `disc_window_eval`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `score_valid` is 0, `mismatch` is 0 and `score` is 0.
- R2: Each window is made of `WIN_LEN` counted samples. In the cycle after the last of them, `score_valid` is 1 for exactly one cycle and `score` equals the sum over the window of (lane_a − lane_b)², with the lanes read as unsigned numbers.
- R3: If the true sum exceeds 2^ACC_W − 1, the reported score is exactly 2^ACC_W − 1.
- R4: A cycle with `smp_valid` low adds nothing, does not advance the window and never raises `mismatch`, whatever the lane values are.
- R5: After reset and after every `cfg_change`, the first `SKIP_LEN` samples with `smp_valid` high are discarded. They do not count toward the window, add nothing to the sum and raise no `mismatch`.
- R6: A cycle with `cfg_change` high drops the partial window and ignores its own sample. In the next cycle `score_valid` and `mismatch` are both 0.
- R7: `mismatch` is 1 in the cycle after a counted sample whose lanes differ, and 0 in every other cycle.
- R8: Windows follow one another with no gap. Each window's sum starts from zero, so a window in which the lanes agree everywhere scores 0 even right after a window that scored high.
- R9: `score` keeps its last reported value until the next report. Neither idle cycles nor `cfg_change` alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_change | input | 1 | Datapath rearranged: drop the partial window and restart the skip count |
| smp_valid | input | 1 | Lane values in this cycle form a sample |
| lane_a | input | DATA_W | Output of the first replica lane |
| lane_b | input | DATA_W | Output of the second replica lane |
| mismatch | output | 1 | The previous counted sample had differing lanes |
| score | output | ACC_W | Last reported windowed sum of squared differences |
| score_valid | output | 1 | One-cycle pulse: `score` holds a new result |

## Verification
The bench builds the block with DATA_W=8, WIN_LEN=6, SKIP_LEN=2 and ACC_W=16. A short window makes many window closes and back-to-back windows cheap to reach. With ACC_W=16, six samples at the largest lane gap (255² each) overflow the accumulator, so saturation is reached within a single window. A skip count of two lets restarts that fall in the middle of the skip phase, and restarts that fall in the middle of a window, be mixed into a seeded random run. An independent behavioural model checks that run on every clock.

// File: rtl/disc_eval_pkg.sv
package disc_eval_pkg;

    // Per-cycle decision from the window controller to the datapath.
    typedef struct packed {
        logic take;   // sample is counted in the current window
        logic close;  // sample is the last one of the window
    } win_step_t;

    // Bits needed to hold values 0..n.
    function automatic int unsigned ctr_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/disc_sq_unit.sv
module disc_sq_unit
    import disc_eval_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  take,
    input  logic [DATA_W-1:0]     lane_a,
    input  logic [DATA_W-1:0]     lane_b,
    output logic [2*DATA_W-1:0]   sq_o,
    output logic                  mismatch_o
);
    localparam int unsigned SQ_W = 2 * DATA_W;

    logic [DATA_W-1:0] gap;
    logic              mm_q;

    always_comb begin
        gap  = (lane_a >= lane_b) ? (lane_a - lane_b) : (lane_b - lane_a);
        sq_o = SQ_W'(gap) * SQ_W'(gap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_q <= 1'b0;
        end else begin
            mm_q <= take && (lane_a != lane_b);
        end
    end

    assign mismatch_o = mm_q;

endmodule

// File: rtl/disc_window_ctrl.sv
module disc_window_ctrl
    import disc_eval_pkg::*;
#(
    parameter int unsigned WIN_LEN  = 100,
    parameter int unsigned SKIP_LEN = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      smp_valid,
    output win_step_t step_o
);
    localparam int unsigned SKW = ctr_bits(SKIP_LEN);
    localparam int unsigned WCW = ctr_bits(WIN_LEN);
    localparam logic [SKW-1:0] SKIP_INIT = SKW'(SKIP_LEN);
    localparam logic [WCW-1:0] WIN_LAST  = WCW'(WIN_LEN - 1);

    logic [SKW-1:0] skip_q;
    logic [WCW-1:0] win_q;

    always_comb begin
        step_o.take  = smp_valid && !restart && (skip_q == '0);
        step_o.close = step_o.take && (win_q == WIN_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            skip_q <= SKIP_INIT;
            win_q  <= '0;
        end else if (smp_valid) begin
            if (skip_q != '0) begin
                skip_q <= skip_q - 1'b1;
            end else if (step_o.close) begin
                win_q <= '0;
            end else begin
                win_q <= win_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/disc_accum.sv
module disc_accum
    import disc_eval_pkg::*;
#(
    parameter int unsigned SQ_W  = 16,
    parameter int unsigned ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  win_step_t        step,
    input  logic [SQ_W-1:0]  sq_i,
    output logic [ACC_W-1:0] score_o,
    output logic             score_valid_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   wide;
    logic [ACC_W-1:0] sum;

    always_comb begin
        wide = {1'b0, acc_q} + (ACC_W + 1)'(sq_i);
        sum  = wide[ACC_W] ? {ACC_W{1'b1}} : wide[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q         <= '0;
            score_o       <= '0;
            score_valid_o <= 1'b0;
        end else if (restart) begin
            acc_q         <= '0;
            score_valid_o <= 1'b0;
        end else begin
            score_valid_o <= step.close;
            if (step.close) begin
                score_o <= sum;
                acc_q   <= '0;
            end else if (step.take) begin
                acc_q <= sum;
            end
        end
    end

endmodule

// File: rtl/disc_window_eval.sv
module disc_window_eval
    import disc_eval_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned WIN_LEN  = 100,
    parameter int unsigned SKIP_LEN = 4,
    parameter int unsigned ACC_W    = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_change,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] lane_a,
    input  logic [DATA_W-1:0] lane_b,
    output logic              mismatch,
    output logic [ACC_W-1:0]  score,
    output logic              score_valid
);
    localparam int unsigned SQ_W = 2 * DATA_W;

    win_step_t       step;
    logic [SQ_W-1:0] sq;

    disc_window_ctrl #(
        .WIN_LEN (WIN_LEN),
        .SKIP_LEN(SKIP_LEN)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .restart  (cfg_change),
        .smp_valid(smp_valid),
        .step_o   (step)
    );

    disc_sq_unit #(
        .DATA_W(DATA_W)
    ) u_sq (
        .clk       (clk),
        .rst       (rst),
        .take      (step.take),
        .lane_a    (lane_a),
        .lane_b    (lane_b),
        .sq_o      (sq),
        .mismatch_o(mismatch)
    );

    disc_accum #(
        .SQ_W (SQ_W),
        .ACC_W(ACC_W)
    ) u_acc (
        .clk          (clk),
        .rst          (rst),
        .restart      (cfg_change),
        .step         (step),
        .sq_i         (sq),
        .score_o      (score),
        .score_valid_o(score_valid)
    );

endmodule

// File: rtl/disc_eval_chk.sv
module disc_eval_chk #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned WIN_LEN = 100,
    parameter int unsigned ACC_W   = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_change,
    input logic              smp_valid,
    input logic [DATA_W-1:0] lane_a,
    input logic [DATA_W-1:0] lane_b,
    input logic              mismatch,
    input logic [ACC_W-1:0]  score,
    input logic              score_valid
);
    generate
        if (WIN_LEN > 1) begin : g_pulse
            assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
                score_valid |=> !score_valid);
        end
    endgenerate

    assert_idle_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        score_valid |-> $past(smp_valid));

    assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_change |=> (!score_valid && !mismatch));

    assert_mismatch_cause_R7: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> $past(smp_valid && !cfg_change && (lane_a != lane_b)));

    assert_score_held_R9: assert property (@(posedge clk) disable iff (rst)
        !score_valid |-> $stable(score));

endmodule

bind disc_window_eval disc_eval_chk #(
    .DATA_W (DATA_W),
    .WIN_LEN(WIN_LEN),
    .ACC_W  (ACC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_change (cfg_change),
    .smp_valid  (smp_valid),
    .lane_a     (lane_a),
    .lane_b     (lane_b),
    .mismatch   (mismatch),
    .score      (score),
    .score_valid(score_valid)
);

// File: tb/disc_window_eval_tb.sv
`timescale 1ns/1ps
module disc_window_eval_tb;
    localparam int DW = 8;
    localparam int WL = 6;
    localparam int SK = 2;
    localparam int AW = 16;
    localparam longint MAXV = (longint'(1) << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_change = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] lane_a = '0;
    logic [DW-1:0] lane_b = '0;
    logic          mismatch;
    logic [AW-1:0] score;
    logic          score_valid;

    always #2.5 clk = ~clk;

    disc_window_eval #(
        .DATA_W(DW), .WIN_LEN(WL), .SKIP_LEN(SK), .ACC_W(AW)
    ) u_dut (
        .clk(clk), .rst(rst), .cfg_change(cfg_change), .smp_valid(smp_valid),
        .lane_a(lane_a), .lane_b(lane_b), .mismatch(mismatch),
        .score(score), .score_valid(score_valid)
    );

    int     checks = 0;
    int     fails  = 0;
    string  tag    = "R1";
    int     m_skip, m_cnt;
    longint m_acc, e_score;
    bit     e_sv, e_mm;
    int unsigned seed = 32'h1234_5678;

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic model_reset();
        m_skip = SK; m_cnt = 0; m_acc = 0; e_score = 0; e_sv = 0; e_mm = 0;
    endtask

    // Drive one cycle from a negedge, update the model at the posedge,
    // compare at the following negedge.
    task automatic cyc(input bit v, input int a, input int b, input bit cfg);
        int d;
        bit take;
        smp_valid = v; lane_a = DW'(a); lane_b = DW'(b); cfg_change = cfg;
        @(posedge clk);
        e_sv = 0;
        if (cfg) begin
            m_skip = SK; m_cnt = 0; m_acc = 0; e_mm = 0;
        end else begin
            take = v && (m_skip == 0);
            e_mm = take && (a != b);
            if (v && m_skip > 0) m_skip--;
            if (take) begin
                d = (a > b) ? a - b : b - a;
                m_acc = m_acc + longint'(d) * d;
                if (m_acc > MAXV) m_acc = MAXV;
                if (m_cnt == WL - 1) begin
                    e_sv = 1; e_score = m_acc; m_acc = 0; m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
        end
        @(negedge clk);
        chk(tag, "score_valid", longint'(score_valid), longint'(e_sv));
        chk(tag, "mismatch", longint'(mismatch), longint'(e_mm));
        chk(tag, "score", longint'(score), e_score);
    endtask

    function automatic int rnd8();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint sum;
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is still asserted
        chk("R1", "score_valid in reset", longint'(score_valid), 0);
        chk("R1", "mismatch in reset", longint'(mismatch), 0);
        chk("R1", "score in reset", longint'(score), 0);
        rst = 1'b0;
        model_reset();
        tag = "R1";
        cyc(0, 0, 0, 0);

        // R5: two skipped samples with large gaps, then an agreeing window
        tag = "R5";
        cyc(1, 200, 0, 0);
        chk("R5", "no mismatch on skipped sample", longint'(mismatch), 0);
        cyc(1, 0, 250, 0);
        for (int i = 0; i < WL; i++) cyc(1, i * 7, i * 7, 0);
        chk("R5", "report after skip", longint'(score_valid), 1);
        chk("R5", "skipped samples excluded", longint'(score), 0);

        // R2: window with known gaps
        tag = "R2";
        sum = 0;
        for (int i = 0; i < WL; i++) begin
            cyc(1, 10 + 5 * i, 3 * i, 0);
            sum += longint'(10 + 2 * i) * (10 + 2 * i);
        end
        chk("R2", "window sum of squares", longint'(score), sum);
        chk("R2", "report pulse", longint'(score_valid), 1);
        cyc(0, 0, 0, 0);
        chk("R2", "pulse lasts one cycle", longint'(score_valid), 0);

        // R4: invalid cycles carry disagreeing lanes
        tag = "R4";
        for (int i = 0; i < WL; i++) begin
            cyc(0, 0, 255, 0);
            chk("R4", "no mismatch on idle cycle", longint'(mismatch), 0);
            cyc(1, 40, 40, 0);
        end
        chk("R4", "idle cycles add nothing", longint'(score), 0);

        // R7: mismatch flag follows counted samples
        tag = "R7";
        cyc(1, 9, 8, 0);
        chk("R7", "mismatch after differing sample", longint'(mismatch), 1);
        cyc(1, 8, 8, 0);
        chk("R7", "mismatch clears on agreement", longint'(mismatch), 0);
        for (int i = 0; i < WL - 2; i++) cyc(1, 1, 1, 0);
        chk("R7", "window score", longint'(score), 1);

        // R3: saturation
        tag = "R3";
        for (int i = 0; i < WL; i++) cyc(1, 0, 255, 0);
        chk("R3", "saturated score", longint'(score), MAXV);

        // R6: restart mid-window, then skip, then a clean window
        tag = "R6";
        for (int i = 0; i < 3; i++) cyc(1, 100, 0, 0);
        cyc(1, 0, 100, 1);
        chk("R6", "no report after restart", longint'(score_valid), 0);
        chk("R6", "no mismatch after restart", longint'(mismatch), 0);
        cyc(1, 50, 0, 0);
        cyc(1, 0, 50, 0);
        for (int i = 0; i < WL; i++) cyc(1, 21, 20, 0);
        chk("R6", "partial window dropped", longint'(score), WL);

        // R8: back-to-back windows, high then agreeing
        tag = "R8";
        for (int i = 0; i < WL; i++) cyc(1, 2, 0, 0);
        chk("R8", "first window", longint'(score), 4 * WL);
        for (int i = 0; i < WL; i++) cyc(1, 77, 77, 0);
        chk("R8", "next window starts at zero", longint'(score), 0);

        // R9: score holds over idle cycles and a restart
        tag = "R9";
        for (int i = 0; i < WL; i++) cyc(1, 3, 0, 0);
        for (int i = 0; i < 5; i++) cyc(0, 1, 2, 0);
        cyc(0, 0, 0, 1);
        chk("R9", "score held", longint'(score), 9 * WL);

        // Mixed random traffic with occasional restarts
        tag = "R2";
        for (int i = 0; i < 600; i++) begin
            int a, b, r;
            r = rnd8();
            a = rnd8();
            b = (r < 128) ? a : rnd8();
            cyc(r[0] | r[1], a, b, r > 245);
        end

        finish_run();
    end
endmodule